// File: doc/BRIEF.md
# Coded Reference Frequency Divider

This block takes the crystal reference clock of a frequency synthesizer (up to 12 MHz) and divides it by a ratio picked with a 4-bit code. The result is the comparison frequency fed to the phase detector. There are two families of ratios. When the top code bit is clear, the ratio is a power of two from 2 to 256. When it is set, the ratio is five times a power of two, from 5 to 320. One code in the upper family has no ratio. It raises an invalid-code flag and leaves the running ratio as it was.

The block has two outputs. One is a square wave that is high for the first half of each period, rounded down. The other is a one-cycle strobe that marks the start of each period. A new code takes effect only at the end of the period in progress, so no output period is ever cut short or stretched by a ratio change. After the synchronous reset the ratio is 2, which matches a control word of all zeros.

Top module: `ref_ratio_divider`

## Requirements
- R1: With code bit 3 at 0, codes 0 to 7 give output periods of 2, 4, 8, 16, 32, 64, 128 and 256 reference cycles (2 shifted left by bits 2..0).
- R2: With code bit 3 at 1, codes 9 to 15 give periods of 5, 10, 20, 40, 80, 160 and 320 cycles (5 shifted left by bits 2..0 minus one).
- R3: `code_bad_o` is 1 in the same cycle that the code is 4'b1000, and 0 for every other code.
- R4: While the code is 4'b1000, the ratio in use does not change. This also holds straight after reset, when the ratio is 2.
- R5: A code change takes effect only at the terminal count. The period in progress completes at the old ratio.
- R6: In each period of ratio N, `div_o` is high for floor(N/2) cycles, then low for the remaining N - floor(N/2) cycles.
- R7: `pulse_o` is high for exactly one cycle per period, the first high cycle of `div_o`.
- R8: While `rst_ni` is low at a clock edge, the divider returns to count 0 with ratio 2. In that state `div_o` and `pulse_o` are both 1. The first period after release lasts 2 cycles, and the input code is loaded at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ratio_code_i | input | 4 | Ratio selection code; bit 3 selects the family |
| div_o | output | 1 | Divided square wave (registered) |
| pulse_o | output | 1 | One-cycle strobe at the start of each period (registered) |
| code_bad_o | output | 1 | High while the code is the reserved value 4'b1000 |

## Verification
The hardest case to reach from the ports is a code change in the middle of a long period. The design has to hold the old ratio for the rest of that period and switch exactly at its end. The stimulus sets the longest ratio (320) and waits for the start strobe. It then changes the code ten cycles into the period and counts cycles up to the next strobe, which must be 320, before checking that the new ratio of 2 applies to the following period. A reserved code is applied both while a ratio of 5 is running and while reset is held, so that retention of the last valid ratio and of the reset ratio are each observed through the period length.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the coded reference divider.
// Assumes the code has one family bit above SEL_W selector bits.
package refdiv_pkg;
    localparam int SEL_W     = 3;   // selector bits below the family bit
    localparam int CODE_W    = SEL_W + 1;
    localparam int POW_BASE  = 2;   // smallest ratio of the power-of-two family
    localparam int ODD_BASE  = 5;   // smallest ratio of the x5 family
    localparam int POW_MAX   = POW_BASE << ((1 << SEL_W) - 1);
    localparam int ODD_MAX   = ODD_BASE << ((1 << SEL_W) - 2);
    localparam int MAX_RATIO = (POW_MAX > ODD_MAX) ? POW_MAX : ODD_MAX;
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef logic [CNT_W-1:0] ratio_t;

    localparam ratio_t RESET_RATIO = ratio_t'(POW_BASE);
endpackage

// File: rtl/refdiv_decode.sv
`timescale 1ns/1ps
// Decodes the ratio code into a division ratio and a validity flag.
// Purely combinational. The code with the family bit set and a zero
// selector is reserved and reported invalid.
module refdiv_decode
    import refdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output ratio_t            ratio_o,
    output logic              valid_o
);
    logic [SEL_W-1:0] sel;
    logic             fam;

    assign sel = code_i[SEL_W-1:0];
    assign fam = code_i[SEL_W];

    // Map family and selector onto the ratio.
    always_comb begin
        valid_o = 1'b1;
        ratio_o = ratio_t'(POW_BASE) << sel;
        if (fam) begin
            if (sel == '0) begin
                valid_o = 1'b0;
                ratio_o = '0;
            end else begin
                ratio_o = ratio_t'(ODD_BASE) << (sel - SEL_W'(1));
            end
        end
    end
endmodule

// File: rtl/refdiv_ratio_reg.sv
`timescale 1ns/1ps
// Holds the ratio in use. A decoded ratio is accepted only on the
// terminal-count cycle and only when the code is valid.
module refdiv_ratio_reg
    import refdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   tc_i,
    input  logic   valid_i,
    input  ratio_t ratio_i,
    output ratio_t ratio_o
);
    ratio_t ratio_q;

    // Load a new ratio at the period boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            ratio_q <= RESET_RATIO;
        else if (tc_i && valid_i)
            ratio_q <= ratio_i;
    end

    assign ratio_o = ratio_q;
endmodule

// File: rtl/refdiv_counter.sv
`timescale 1ns/1ps
// Period counter with registered square-wave and start-strobe outputs.
// Assumes a ratio of at least 2 that does not change between terminal counts.
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  ratio_t ratio_i,
    output ratio_t cnt_o,
    output logic   tc_o,
    output logic   div_o,
    output logic   pulse_o
);
    ratio_t cnt_q;
    ratio_t cnt_next;
    ratio_t half;
    logic   div_q;
    logic   pulse_q;

    assign half = ratio_i >> 1;
    assign tc_o = (cnt_q == ratio_i - ratio_t'(1));

    // Advance the count and wrap it at the terminal count.
    always_comb begin
        if (tc_o) cnt_next = '0;
        else      cnt_next = cnt_q + ratio_t'(1);
    end

    // Register the count and both outputs from the next count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            div_q   <= 1'b1;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_next;
            div_q   <= tc_o ? 1'b1 : (cnt_next < half);
            pulse_q <= tc_o;
        end
    end

    assign cnt_o   = cnt_q;
    assign div_o   = div_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/ref_ratio_divider.sv
`timescale 1ns/1ps
// Coded reference frequency divider: divides the reference clock by a
// ratio chosen with a 4-bit code, switching ratios only at period ends.
// Assumes a synchronous active-low reset and a code that is static
// relative to clk_i.
module ref_ratio_divider
    import refdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] ratio_code_i,
    output logic              div_o,
    output logic              pulse_o,
    output logic              code_bad_o
);
    ratio_t dec_ratio;
    logic   dec_valid;
    ratio_t ratio_w;
    ratio_t cnt_w;
    logic   tc_w;

    refdiv_decode u_dec (
        .code_i  (ratio_code_i),
        .ratio_o (dec_ratio),
        .valid_o (dec_valid)
    );

    refdiv_ratio_reg u_ratio (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tc_i    (tc_w),
        .valid_i (dec_valid),
        .ratio_i (dec_ratio),
        .ratio_o (ratio_w)
    );

    refdiv_counter u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ratio_i (ratio_w),
        .cnt_o   (cnt_w),
        .tc_o    (tc_w),
        .div_o   (div_o),
        .pulse_o (pulse_o)
    );

    assign code_bad_o = ~dec_valid;
endmodule

// File: rtl/refdiv_checker.sv
`timescale 1ns/1ps
// Property checker for the coded reference divider, bound to the top.
module refdiv_checker
    import refdiv_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CODE_W-1:0] ratio_code_i,
    input logic              div_o,
    input logic              pulse_o,
    input logic              code_bad_o,
    input ratio_t            cnt,
    input ratio_t            ratio
);
    logic at_end;
    assign at_end = (cnt == ratio - ratio_t'(1));

    assert_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio_code_i == 4'b1000) |-> code_bad_o);
    assert_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ratio_code_i[CODE_W-1] |-> !code_bad_o);
    assert_keep_ratio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_end && code_bad_o) |=> $stable(ratio));
    assert_switch_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ratio) |-> pulse_o);
    assert_cnt_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt < ratio);
    assert_pulse_in_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> div_o);
    assert_rise_has_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_o) |-> pulse_o);
endmodule

bind ref_ratio_divider refdiv_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ratio_code_i (ratio_code_i),
    .div_o        (div_o),
    .pulse_o      (pulse_o),
    .code_bad_o   (code_bad_o),
    .cnt          (cnt_w),
    .ratio        (ratio_w)
);

// File: tb/ref_ratio_divider_test.sv
`timescale 1ns/1ps
// Self-checking bench for the coded reference divider.
module ref_ratio_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd0;
    logic       div_w, pulse_w, bad_w;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ref_ratio_divider uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ratio_code_i (code),
        .div_o        (div_w),
        .pulse_o      (pulse_w),
        .code_bad_o   (bad_w)
    );

    localparam int NVEC = 15;
    localparam logic [3:0] VEC_CODE [0:NVEC-1] = '{
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
        4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
    localparam int VEC_RATIO [0:NVEC-1] = '{
        2, 4, 8, 16, 32, 64, 128, 256, 5, 10, 20, 40, 80, 160, 320};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next negedge at which the start strobe is high.
    task automatic wait_pulse();
        @(negedge clk);
        for (int i = 0; i < 1000 && !pulse_w; i++) @(negedge clk);
    endtask

    // Measure one period starting at a negedge with the strobe high.
    task automatic measure(input int ratio, input string tag);
        int h = 0;
        int l = 0;
        int extra = 0;
        while (div_w && h < 1000) begin
            if (h > 0 && pulse_w) extra++;
            h++;
            @(negedge clk);
        end
        while (!div_w && l < 1000) begin
            if (pulse_w) extra++;
            l++;
            @(negedge clk);
        end
        check(h == ratio / 2, {tag, " high cycles R6"}, h, ratio / 2);
        check(l == ratio - ratio / 2, {tag, " low cycles R6"}, l, ratio - ratio / 2);
        check(h + l == ratio, {tag, " period"}, h + l, ratio);
        check(extra == 0 && pulse_w, {tag, " strobe R7"}, extra, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // Reset state (R8)
        do_reset();
        check(div_w == 1'b1, "R8 div in reset", div_w, 1);
        check(pulse_w == 1'b1, "R8 strobe in reset", pulse_w, 1);
        check(bad_w == 1'b0, "R3 flag for code 0", bad_w, 0);
        rst_n = 1'b1;

        // Table walk over every valid code (R1, R2)
        for (int i = 0; i < NVEC; i++) begin
            code = VEC_CODE[i];
            #1;
            check(bad_w == 1'b0, "R3 flag clear for valid code", bad_w, 0);
            wait_pulse();
            measure(VEC_RATIO[i], VEC_CODE[i][3] ? "R2" : "R1");
            measure(VEC_RATIO[i], VEC_CODE[i][3] ? "R2 repeat" : "R1 repeat");
        end

        // Reserved code while ratio 5 runs (R3, R4)
        code = 4'd9;
        wait_pulse();
        measure(5, "R4 before reserved");
        code = 4'b1000;
        #1;
        check(bad_w == 1'b1, "R3 flag for reserved code", bad_w, 1);
        for (int k = 0; k < 3; k++) measure(5, "R4 hold ratio 5");

        // Reserved code during reset keeps the reset ratio (R4, R8)
        do_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check(div_w == 1'b0, "R8 first low cycle", div_w, 0);
        @(negedge clk);
        check(pulse_w == 1'b1, "R8 second period start", pulse_w, 1);
        measure(2, "R4 reset ratio kept");
        measure(2, "R4 reset ratio kept again");

        // Mid-period change during a 320 period (R5)
        code = 4'd15;
        wait_pulse();
        measure(320, "R5 long ratio");
        begin
            int n = 0;
            repeat (10) begin n++; @(negedge clk); end
            code = 4'd0;
            while (!pulse_w && n < 1000) begin n++; @(negedge clk); end
            check(n == 320, "R5 old period completes", n, 320);
        end
        measure(2, "R5 new ratio applied");

        // Reset in the middle of a long period (R8)
        code = 4'd15;
        wait_pulse();
        repeat (7) @(negedge clk);
        do_reset();
        check(div_w == 1'b1 && pulse_w == 1'b1, "R8 mid-run reset outputs", {div_w, pulse_w}, 3);
        rst_n = 1'b1;
        measure(2, "R8 first period after reset");
        measure(320, "R8 code loaded after first period");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule